// File: doc/BRIEF.md
# Converter Serial Output Port

This block takes each 16-bit result from a converter's sequencer and shifts it out, most significant bit first, on a single serial data line. It works as a clock master or as a clock slave. As master it makes its own serial clock, with one of four divide ratios, and drives a frame-sync output whose active level can be chosen. As slave it shifts on an external clock. Chip select gates that clock, and a serial input passes through, so several converters can share one data line in a chain.

Both modes share a set of static mode inputs. Output coding is straight binary or two's complement. A clock-invert control selects which pin edge updates the data. In master mode, a read-mode control sends either the fresh result after its conversion ends, or the result held from the previous conversion while the next one runs. In slave mode, a read that is still running when a new result lands loses the old data and raises a one-cycle error pulse. The pins are plain outputs, each paired with an output-enable. The enables are high only when chip select and read are both low.

The block is fully synchronous to `clk`. In slave mode the external clock and the serial input are oversampled through two-stage synchronizers, so the external clock must be slower than `clk`.

Top module: `adc_serial_port`

## Requirements
- R1: In master mode a frame carries the 16 result bits most significant bit first. Each bit is presented on `sdo` at the update edge of a serial clock period and stays valid through the opposite (sample) edge.
- R2: With `straight_bin`=1 the bits sent equal the result. With `straight_bin`=0 bit 15 is inverted (two's complement) and the other bits are unchanged.
- R3: In slave mode, an edge on `sclk_in` shifts data only while `cs_n`=0. Edges seen while `cs_n`=1 leave `sdo` unchanged and do not advance the read.
- R4: `sync_out` sits at level `sync_act_low` while idle. It is at the opposite level during a master frame: active high when `sync_act_low`=0, active low when it is 1.
- R5: The serial clock pin idles at level `sclk_invert`. The update edge is rising when `sclk_invert`=0 and falling when it is 1. `sdo` changes only at update edges, apart from clearing to 0 on the cycle a master frame starts.
- R6: In master read-after-convert mode (`read_during`=0) a frame starts on `res_valid`. Each serial clock half period lasts 2^`div_sel` cycles of `clk` (divide-by 1, 2, 4, 8), so sync stays active for 32*2^`div_sel` cycles.
- R7: In master read-during-convert mode (`read_during`=1) a frame starts on `conv_start`. It sends the result latched at the last `res_valid`, uses a half period of one `clk` cycle, and is not disturbed by a `res_valid` that arrives during the frame.
- R8: In slave mode the `sdin` level sampled at update edge k of a read appears on `sdo` at update edge k+16.
- R9: In slave mode, a `res_valid` that arrives after 1 to 15 update edges of a read sets `rd_err` high for exactly the next cycle and reloads the new result. After 0 or 16 or more edges it raises no error.
- R10: `sdo_oe` is 1 only when `cs_n`=0 and `rd_n`=0. `sclk_oe` and `sync_oe` also require master mode (`slave_sel`=0).
- R11: A master frame has exactly 16 update edges. After sync returns to idle, no further serial clock edges appear until the next start.
- R12: After reset `rd_err`=0, `sdo`=0, sync is at its idle level and the serial clock is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| res_data | input | 16 | Conversion result from the sequencer |
| res_valid | input | 1 | One-cycle strobe: result ready |
| conv_start | input | 1 | One-cycle strobe: conversion begins |
| slave_sel | input | 1 | 0 master clock, 1 external clock |
| straight_bin | input | 1 | 1 straight binary, 0 two's complement |
| sync_act_low | input | 1 | Sync active level select (1 = active low) |
| sclk_invert | input | 1 | Serial clock inversion |
| read_during | input | 1 | Master: 1 read previous result during conversion |
| div_sel | input | 2 | Master clock divide select |
| cs_n | input | 1 | Chip select, active low; gates external clock |
| rd_n | input | 1 | Read enable, active low |
| sclk_in | input | 1 | External serial clock (slave) |
| sdin | input | 1 | Daisy-chain serial input (slave) |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for sdo |
| sclk_out | output | 1 | Generated serial clock (master) |
| sclk_oe | output | 1 | Output enable for sclk_out |
| sync_out | output | 1 | Frame sync (master) |
| sync_oe | output | 1 | Output enable for sync_out |
| rd_err | output | 1 | Incomplete-read error pulse (slave) |

## Verification
The bench rebuilds each master word from the sample edges at all four divide ratios, both sync polarities and both clock senses. A wrong edge choice shows up as a shifted or repeated bit, and a wrong divider shows up as a sync width other than 32*2^div cycles. In slave mode it runs reads of 24 edges. A daisy-chain delay off by one shows up as misplaced `sdin` bits after edge 16, and a missing chip-select gate shows up as skipped bits. The error pulse is tested both for a read cut short after five edges, where it must fire and the new word must follow, and for a read that is already complete, where it must stay low. Read-during-convert frames take a `res_valid` in the middle of the frame, which a design that reloads there would corrupt.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;

    typedef enum logic [1:0] {
        DIV_BY1 = 2'd0,
        DIV_BY2 = 2'd1,
        DIV_BY4 = 2'd2,
        DIV_BY8 = 2'd3
    } sclk_div_e;

    typedef struct packed {
        logic      slave;
        logic      straight;
        logic      sync_lo;
        logic      inv;
        logic      rd_during;
        sclk_div_e div;
    } port_mode_t;

    // Output coding: two's complement flips the top bit only.
    function automatic logic coded_msb(input logic msb, input logic straight);
        return straight ? msb : ~msb;
    endfunction

endpackage

// File: rtl/adcsp_master_gen.sv
module adcsp_master_gen #(
    parameter int NBITS = 16,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             fast,
    input  logic [DIV_W-1:0] div,
    output logic             active,
    output logic             ph,
    output logic             upd
);
    localparam int NEDGE = 2 * NBITS;
    localparam int EW    = $clog2(NEDGE);
    localparam int HC_W  = 1 << DIV_W;

    logic [EW-1:0]   edges;
    logic [HC_W-1:0] hcnt;
    logic [HC_W-1:0] lim;
    logic            tick;

    always_comb begin
        lim  = fast ? '0 : HC_W'((32'd1 << div) - 32'd1);
        tick = active && (hcnt == lim);
        upd  = tick && !ph;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ph     <= 1'b0;
            hcnt   <= '0;
            edges  <= '0;
        end else if (start) begin
            active <= 1'b1;
            ph     <= 1'b0;
            hcnt   <= '0;
            edges  <= '0;
        end else if (tick) begin
            hcnt  <= '0;
            ph    <= ~ph;
            edges <= edges + 1'b1;
            if (edges == EW'(NEDGE - 1))
                active <= 1'b0;
        end else if (active) begin
            hcnt <= hcnt + 1'b1;
        end
    end
endmodule

// File: rtl/adcsp_slave_trk.sv
module adcsp_slave_trk #(
    parameter int NBITS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic cs_n,
    input  logic sck,
    input  logic inv,
    input  logic sdin,
    input  logic load,
    output logic upd,
    output logic sdin_q,
    output logic rd_err
);
    localparam int CW = $clog2(NBITS + 1);

    logic [2:0]    sck_p;
    logic [1:0]    sd_p;
    logic [CW-1:0] cnt;

    assign upd    = en && !cs_n && sck_p[1] && !sck_p[2];
    assign sdin_q = sd_p[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p  <= '0;
            sd_p   <= '0;
            cnt    <= CW'(NBITS);
            rd_err <= 1'b0;
        end else begin
            sck_p  <= {sck_p[1:0], sck ^ inv};
            sd_p   <= {sd_p[0], sdin};
            rd_err <= 1'b0;
            if (load) begin
                rd_err <= en && (cnt != '0) && (cnt != CW'(NBITS));
                cnt    <= '0;
            end else if (upd && cnt != CW'(NBITS)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adcsp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_valid,
    input  logic              conv_start,
    input  logic              slave_sel,
    input  logic              straight_bin,
    input  logic              sync_act_low,
    input  logic              sclk_invert,
    input  logic              read_during,
    input  logic [1:0]        div_sel,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              sclk_in,
    input  logic              sdin,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sync_out,
    output logic              sync_oe,
    output logic              rd_err
);
    port_mode_t        cfg;
    logic [DATA_W-1:0] coded;
    logic [DATA_W-1:0] sreg;
    logic [DATA_W-1:0] held;
    logic              sdo_q;
    logic              m_start, m_active, m_ph, m_upd;
    logic              s_upd, s_sdin, s_load;
    logic              bus_en;

    always_comb begin
        cfg.slave     = slave_sel;
        cfg.straight  = straight_bin;
        cfg.sync_lo   = sync_act_low;
        cfg.inv       = sclk_invert;
        cfg.rd_during = read_during;
        cfg.div       = sclk_div_e'(div_sel);
        coded = {coded_msb(res_data[DATA_W-1], cfg.straight), res_data[DATA_W-2:0]};
        m_start = !cfg.slave && (cfg.rd_during ? conv_start : res_valid);
        s_load  = cfg.slave && res_valid;
    end

    adcsp_master_gen #(.NBITS(DATA_W), .DIV_W(2)) u_mgen (
        .clk    (clk),
        .rst    (rst),
        .start  (m_start),
        .fast   (cfg.rd_during),
        .div    (cfg.div),
        .active (m_active),
        .ph     (m_ph),
        .upd    (m_upd)
    );

    adcsp_slave_trk #(.NBITS(DATA_W)) u_strk (
        .clk    (clk),
        .rst    (rst),
        .en     (cfg.slave),
        .cs_n   (cs_n),
        .sck    (sclk_in),
        .inv    (cfg.inv),
        .sdin   (sdin),
        .load   (s_load),
        .upd    (s_upd),
        .sdin_q (s_sdin),
        .rd_err (rd_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg  <= '0;
            held  <= '0;
            sdo_q <= 1'b0;
        end else begin
            if (res_valid)
                held <= coded;
            if (m_start) begin
                sreg  <= cfg.rd_during ? held : coded;
                sdo_q <= 1'b0;
            end else if (s_load) begin
                sreg <= coded;
            end else if (!cfg.slave && m_upd) begin
                sdo_q <= sreg[DATA_W-1];
                sreg  <= {sreg[DATA_W-2:0], 1'b0};
            end else if (s_upd) begin
                sdo_q <= sreg[DATA_W-1];
                sreg  <= {sreg[DATA_W-2:0], s_sdin};
            end
        end
    end

    always_comb begin
        bus_en   = !cs_n && !rd_n;
        sdo      = sdo_q;
        sdo_oe   = bus_en;
        sclk_out = m_ph ^ cfg.inv;
        sclk_oe  = bus_en && !cfg.slave;
        sync_out = m_active ^ cfg.sync_lo;
        sync_oe  = bus_en && !cfg.slave;
    end
endmodule

// File: rtl/adcsp_chk.sv
module adcsp_chk (
    input logic clk,
    input logic rst,
    input logic slave_sel,
    input logic cs_n,
    input logic res_valid,
    input logic sclk_invert,
    input logic sync_act_low,
    input logic sclk_out,
    input logic sync_out,
    input logic sdo,
    input logic rd_err
);
    // R11
    idle_no_clock_chk: assert property (@(posedge clk) disable iff (rst)
        (!slave_sel && sync_out == sync_act_low && $past(sync_out) == sync_act_low
         && $stable(sclk_invert) && $stable(sync_act_low)) |-> $stable(sclk_out));

    // R9
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        rd_err |=> !rd_err);

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> ($past(res_valid) && $past(slave_sel)));

    // R3
    cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (slave_sel && $past(slave_sel) && $past(cs_n)) |-> $stable(sdo));
endmodule

bind adc_serial_port adcsp_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .slave_sel    (slave_sel),
    .cs_n         (cs_n),
    .res_valid    (res_valid),
    .sclk_invert  (sclk_invert),
    .sync_act_low (sync_act_low),
    .sclk_out     (sclk_out),
    .sync_out     (sync_out),
    .sdo          (sdo),
    .rd_err       (rd_err)
);

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] res_data = '0;
    logic        res_valid = 1'b0, conv_start = 1'b0;
    logic        slave_sel = 1'b0, straight_bin = 1'b1, sync_act_low = 1'b0;
    logic        sclk_invert = 1'b0, read_during = 1'b0;
    logic [1:0]  div_sel = 2'd0;
    logic        cs_n = 1'b0, rd_n = 1'b0, sclk_in = 1'b0, sdin = 1'b0;
    logic        sdo, sdo_oe, sclk_out, sclk_oe, sync_out, sync_oe, rd_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_serial_port dut (
        .clk(clk), .rst(rst), .res_data(res_data), .res_valid(res_valid),
        .conv_start(conv_start), .slave_sel(slave_sel), .straight_bin(straight_bin),
        .sync_act_low(sync_act_low), .sclk_invert(sclk_invert), .read_during(read_during),
        .div_sel(div_sel), .cs_n(cs_n), .rd_n(rd_n), .sclk_in(sclk_in), .sdin(sdin),
        .sdo(sdo), .sdo_oe(sdo_oe), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .sync_out(sync_out), .sync_oe(sync_oe), .rd_err(rd_err)
    );

    function automatic logic [15:0] fmt(input logic [15:0] d, input logic st);
        return st ? d : {~d[15], d[14:0]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_valid(input logic [15:0] d);
        res_data = d; res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic run_master(input logic [15:0] d, input logic st, input logic [1:0] dv,
                              input logic sl, input logic iv, input logic rdd);
        logic [15:0] got, exp;
        int nup, nsync, badupd, nexp;
        logic pph, ph, psdo;
        slave_sel = 1'b0; straight_bin = st; div_sel = dv; sync_act_low = sl;
        sclk_invert = iv; read_during = rdd;
        repeat (3) @(negedge clk);
        // R5 R4 idle levels
        check(sclk_out == iv, "R5 idle clock level", sclk_out, iv);
        check(sync_out == sl, "R4 idle sync level", sync_out, sl);
        exp = fmt(d, st);
        if (rdd) begin
            pulse_valid(d);
            repeat (2) @(negedge clk);
            check(sync_out == sl, "R7 no frame on res_valid", sync_out, sl);
            conv_start = 1'b1;
            @(negedge clk);
            conv_start = 1'b0;
        end else begin
            pulse_valid(d);
        end
        got = '0; nup = 0; nsync = 0; badupd = 0; pph = 1'b0; psdo = sdo;
        for (int c = 0; c < 300; c++) begin
            ph = sclk_out ^ iv;
            if (sync_out != sl) nsync++;
            if (ph && !pph) nup++;
            if (!ph && pph) got = {got[14:0], sdo};
            if (sdo != psdo && !(ph && !pph)) badupd++;
            pph = ph; psdo = sdo;
            if (rdd && c == 6) pulse_valid(~d);
            else @(negedge clk);
        end
        nexp = rdd ? 32 : (32 << dv);
        check(got == exp, st ? "R1 master word" : "R2 twos complement word", got, exp);
        check(nup == 16, "R11 update edge count", nup, 16);
        check(nsync == nexp, rdd ? "R7 sync width" : "R6 sync width", nsync, nexp);
        check(badupd == 0, "R5 sdo changes only at update edge", badupd, 0);
    endtask

    task automatic s_edge(input logic sd, output logic q);
        sdin = sd;
        sclk_in = ~sclk_invert;
        repeat (5) @(negedge clk);
        q = sdo;
        sclk_in = sclk_invert;
        repeat (5) @(negedge clk);
    endtask

    task automatic run_slave(input logic [15:0] d, input logic st, input logic iv);
        logic [15:0] exp;
        logic [23:0] hist;
        logic q;
        int bad;
        slave_sel = 1'b1; straight_bin = st; sclk_invert = iv; sclk_in = iv; cs_n = 1'b0;
        repeat (4) @(negedge clk);
        pulse_valid(d);
        check(rd_err == 1'b0, "R9 no error on fresh load", rd_err, 0);
        exp = fmt(d, st);
        bad = 0;
        for (int k = 0; k < 24; k++) begin
            hist[k] = 1'($urandom);
            s_edge(hist[k], q);
            if (k < 16) begin
                if (q != exp[15-k]) bad++;
            end else if (q != hist[k-16]) begin
                bad++;
            end
        end
        check(bad == 0 || !st, "R1 slave word", bad, 0);
        check(bad == 0, "R8 daisy chain after 16 edges", bad, 0);
        // R9: read already complete, no error
        pulse_valid(d ^ 16'h00ff);
        check(rd_err == 1'b0, "R9 no error after full read", rd_err, 0);
    endtask

    initial begin
        logic [15:0] d;
        logic q, held_q;
        void'($urandom(32'd2025));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(rd_err == 1'b0, "R12 rd_err after reset", rd_err, 0);
        check(sdo == 1'b0, "R12 sdo after reset", sdo, 0);
        check(sync_out == 1'b0, "R12 sync idle after reset", sync_out, 0);
        check(sclk_out == 1'b0, "R12 clock idle after reset", sclk_out, 0);

        // R10 output enables
        cs_n = 1'b0; rd_n = 1'b1; @(negedge clk);
        check(sdo_oe == 1'b0, "R10 oe off with rd_n high", sdo_oe, 0);
        cs_n = 1'b1; rd_n = 1'b0; @(negedge clk);
        check(sdo_oe == 1'b0 && sclk_oe == 1'b0, "R10 oe off with cs_n high", sdo_oe, 0);
        cs_n = 1'b0; @(negedge clk);
        check(sdo_oe && sclk_oe && sync_oe, "R10 oe on in master", {sdo_oe, sclk_oe, sync_oe}, 7);

        // directed master frames
        run_master(16'h8001, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
        run_master(16'h8001, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0);
        run_master(16'h3c5a, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0);
        run_master(16'hffff, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0);
        run_master(16'ha5c3, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1);
        // random master frames
        for (int i = 0; i < 8; i++) begin
            d = 16'($urandom);
            run_master(d, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        // slave mode
        @(negedge clk);
        slave_sel = 1'b1; @(negedge clk);
        check(sdo_oe == 1'b1 && sclk_oe == 1'b0 && sync_oe == 1'b0, "R10 slave oe",
              {sdo_oe, sclk_oe, sync_oe}, 4);
        run_slave(16'hc3a5, 1'b1, 1'b0);
        run_slave(16'h1234, 1'b0, 1'b1);
        run_slave(16'($urandom), 1'b1, 1'b1);

        // R9 interrupted read and R3 chip-select gating
        straight_bin = 1'b1; sclk_invert = 1'b0; sclk_in = 1'b0;
        repeat (3) @(negedge clk);
        pulse_valid(16'hf0f0);
        for (int k = 0; k < 5; k++) s_edge(1'b0, q);
        res_data = 16'h5a5a; res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        check(rd_err == 1'b1, "R9 error on interrupted read", rd_err, 1);
        @(negedge clk);
        check(rd_err == 1'b0, "R9 error lasts one cycle", rd_err, 0);
        s_edge(1'b0, q);
        check(q == 1'b0, "R9 new word bit15 after reload", q, 0);
        s_edge(1'b0, q);
        check(q == 1'b1, "R9 new word bit14 after reload", q, 1);
        held_q = sdo;
        cs_n = 1'b1;
        for (int k = 0; k < 3; k++) s_edge(1'b0, q);
        check(sdo == held_q, "R3 sdo held while cs_n high", sdo, held_q);
        check(sdo_oe == 1'b0, "R10 sdo_oe off while cs_n high", sdo_oe, 0);
        cs_n = 1'b0;
        s_edge(1'b0, q);
        check(q == 1'b0, "R3 bit13 follows after cs_n low", q, 0);
        s_edge(1'b0, q);
        check(q == 1'b1, "R3 bit12 not skipped", q, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule